// File: doc/BRIEF.md
# UART Interrupt Enable and Event Logic

This block is the interrupt front end of a UART. It holds an 8-bit enable register that the host writes and reads through a small register port, and it combines a set of event sources into one active-high interrupt line. Three sources are levels that other UART logic already holds: receive data ready, transmit holding empty and line status error. A fourth is a 4-bit modem status change vector, which counts as an event while any of its bits is set.

Three further sources are short events that are latched here as sticky pending flags. They are a rising edge on the CTS line, a rising edge on the RTS line, and a one-cycle pulse from the flow-control matcher that reports a received Xoff character. These flags are latched whatever the enables say. A host read of the status selector clears them. One enable bit is not an interrupt source at all: it is exported as the sleep-mode enable for the rest of the UART.

Next to the interrupt line, the block drives a 3-bit source code. It names the highest-priority enabled source that is pending, and the same code can be read back through the status selector. The host writes a one-bit selector to choose between the enable register (0) and the status byte (1).

Top module: `uirq_ctrl`

## Requirements
- R1: After synchronous reset every enable bit is 0, `irq` is 0, `irq_src` is 0, `sleep_en` is 0 and `reg_rdata` is 0. With all enables at 0, active event inputs do not raise `irq`.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into the enable register on the next clock edge. A read with `reg_sel`=0 puts the enable register on `reg_rdata` one clock edge after `reg_rd` is sampled.
- R3: Enable bit 4 drives `sleep_en` directly and never raises `irq`.
- R4: Enable bit 0 passes `rx_ready`, bit 1 passes `tx_empty` and bit 2 passes `line_err` to `irq`. These are combinational level sources.
- R5: Enable bit 3 passes a modem event to `irq`. A modem event is present while any bit of `modem_delta` is 1.
- R6: A 0-to-1 transition on `cts_line` sets a sticky CTS flag, and bit 7 enables it. A 0-to-1 transition on `rts_line` sets a sticky RTS flag, and bit 6 enables it. A line held high or falling sets nothing.
- R7: A one-cycle pulse on `xoff_seen` sets a sticky Xoff flag, and bit 5 enables it.
- R8: A read with `reg_sel`=1 returns the status byte {CTS flag, RTS flag, Xoff flag, 2'b00, source code}, using the values before the read. The same edge clears all three flags. If a flag's set event falls on that edge, the set wins.
- R9: `irq_src` names the highest-priority enabled pending source, in this order from highest: 1 line status, 2 receive ready, 3 transmit empty, 4 modem, 5 Xoff, 6 CTS/RTS. It is 0 when none is pending.
- R10: Clearing an enable bit removes its source from `irq` at once. A sticky flag survives this and raises `irq` again when its enable returns.
- R11: `irq` is 1 exactly when at least one enabled source is pending, which is exactly when `irq_src` is non-zero.
- R12: A write with `reg_sel`=1 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_ready | input | 1 | Receive data ready level |
| tx_empty | input | 1 | Transmit holding empty level |
| line_err | input | 1 | Line status error level |
| modem_delta | input | 4 | Modem status change bits |
| xoff_seen | input | 1 | One-cycle pulse when an Xoff character is matched |
| cts_line | input | 1 | CTS level, synchronous to clk |
| rts_line | input | 1 | RTS level, synchronous to clk |
| irq | output | 1 | Active-high interrupt |
| irq_src | output | 3 | Code of the highest-priority pending enabled source |
| sleep_en | output | 1 | Sleep-mode enable for the rest of the UART |

## Verification
A status read that clears the sticky flags can fall on the same edge as a new RTS rising edge, or as a new CTS rising edge and Xoff pulse. The bench provokes this by raising the CTS flag first. It then drives the status read and the RTS rise in the same cycle. It expects the returned byte to show only the old CTS flag. Afterwards the RTS flag should remain, still holding `irq`, and a second status read should report it alone.

// File: rtl/uirq_pkg.sv
// Package for the UART interrupt front end.
// Holds the enable bit positions, the register selector values and the
// source code type. The bit positions are fixed because host software
// decodes them.
package uirq_pkg;

    localparam int DATA_W = 8;

    // Enable register bit positions
    localparam int EN_RXRDY = 0;
    localparam int EN_TXEMP = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_SLEEP = 4;
    localparam int EN_XOFF  = 5;
    localparam int EN_RTS   = 6;
    localparam int EN_CTS   = 7;

    // Register selector values
    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

    // Source codes; a lower non-zero value means a higher priority
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_LINE  = 3'd1,
        SRC_RXRDY = 3'd2,
        SRC_TXEMP = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_XOFF  = 3'd5,
        SRC_HSHK  = 3'd6
    } src_code_e;

    localparam int NUM_SRC = 6;

endpackage

// File: rtl/uirq_enable_reg.sv
// Enable register.
// Loads the write data when wr_en is high and holds it otherwise.
// Assumes the caller has already decoded wr_en for the enable selector.
// Resets to all zeros.
module uirq_enable_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);

    // Enable storage: clear on reset, load on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= wdata;
    end

    AST_IER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q == $past(wdata));                            // R2
    AST_IER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));                                  // R12

endmodule

// File: rtl/uirq_event_latch.sv
// Sticky event flags.
// The first EDGES flags are set by a 0-to-1 transition on their level
// input. The remaining PULSES flags are set by a high pulse. A common
// clear drops every flag, but a set on the same edge takes precedence.
// Assumes all inputs are synchronous to clk.
module uirq_event_latch #(
    parameter int EDGES  = 2,
    parameter int PULSES = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [EDGES-1:0]          edge_in,
    input  logic [PULSES-1:0]         pulse_in,
    input  logic                      clr,
    output logic [EDGES+PULSES-1:0]   pend
);

    localparam int NF = EDGES + PULSES;

    logic [EDGES-1:0] prev_q;
    logic [NF-1:0]    set_ev;

    // Previous line levels; they follow the lines even in reset so that
    // a line that is high at release gives no false edge
    always_ff @(posedge clk) begin
        prev_q <= edge_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < EDGES; gi++) begin : g_edge
            // Rising-edge detect for one line
            assign set_ev[gi] = edge_in[gi] & ~prev_q[gi];
        end
        for (gi = 0; gi < PULSES; gi++) begin : g_pulse
            // Pulse sources set directly
            assign set_ev[EDGES+gi] = pulse_in[gi];
        end
        for (gi = 0; gi < NF; gi++) begin : g_flag
            // One sticky flag: a set beats a clear
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[gi] <= 1'b0;
                else if (set_ev[gi])
                    pend[gi] <= 1'b1;
                else if (clr)
                    pend[gi] <= 1'b0;
            end

            AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
                set_ev[gi] |=> pend[gi]);                           // R8
            AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                pend[gi] && !clr |=> pend[gi]);                     // R6
            AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                clr && !set_ev[gi] |=> !pend[gi]);                  // R8
        end
    endgenerate

endmodule

// File: rtl/uirq_prio.sv
// Fixed-priority source encoder.
// req[0] has the highest priority. The output code is the index of the
// lowest set request plus one, or SRC_NONE when no request is set.
// Assumes the requests are already masked by their enables.
module uirq_prio
    import uirq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [N-1:0] req,
    output src_code_e    code
);

    // Scan from lowest priority to highest so that the last hit wins
    always_comb begin
        code = SRC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                code = src_code_e'(3'(i + 1));
        end
    end

    AST_PRIO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> code == SRC_LINE);                               // R9
    AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        req == '0 |-> code == SRC_NONE);                            // R9

endmodule

// File: rtl/uirq_ctrl.sv
// UART interrupt enable and event logic, top level.
// Decodes the register port, keeps the enable register and the sticky
// flags for CTS, RTS and Xoff, masks every source and encodes a
// priority code. irq and irq_src are combinational from the registered
// state and the level inputs. reg_rdata is registered.
// Assumes every input is synchronous to clk.
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int MSR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_ready,
    input  logic              tx_empty,
    input  logic              line_err,
    input  logic [MSR_W-1:0]  modem_delta,
    input  logic              xoff_seen,
    input  logic              cts_line,
    input  logic              rts_line,
    output logic              irq,
    output logic [2:0]        irq_src,
    output logic              sleep_en
);

    localparam int P_CTS  = 0;
    localparam int P_RTS  = 1;
    localparam int P_XOFF = 2;

    logic [DATA_W-1:0] en_q;
    logic [2:0]        pend;
    logic [NUM_SRC-1:0] masked;
    logic              ier_wr;
    logic              stat_rd;
    src_code_e         code;
    logic [DATA_W-1:0] status_byte;

    // Register port decode
    assign ier_wr  = reg_wr & (reg_sel == SEL_ENABLE);
    assign stat_rd = reg_rd & (reg_sel == SEL_STATUS);

    uirq_enable_reg #(.W(DATA_W)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ier_wr),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    uirq_event_latch #(.EDGES(2), .PULSES(1)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_in  ({rts_line, cts_line}),
        .pulse_in (xoff_seen),
        .clr      (stat_rd),
        .pend     (pend)
    );

    // Masked sources, in priority order from index 0
    always_comb begin
        masked[0] = line_err & en_q[EN_LINE];
        masked[1] = rx_ready & en_q[EN_RXRDY];
        masked[2] = tx_empty & en_q[EN_TXEMP];
        masked[3] = (|modem_delta) & en_q[EN_MODEM];
        masked[4] = pend[P_XOFF] & en_q[EN_XOFF];
        masked[5] = (pend[P_CTS] & en_q[EN_CTS]) | (pend[P_RTS] & en_q[EN_RTS]);
    end

    uirq_prio #(.N(NUM_SRC)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (masked),
        .code  (code)
    );

    // Output drive
    assign irq      = |masked;
    assign irq_src  = code;
    assign sleep_en = en_q[EN_SLEEP];

    // Status byte layout: flags in the top bits, code in the bottom bits
    assign status_byte = {pend[P_CTS], pend[P_RTS], pend[P_XOFF], 2'b00, code};

    // Registered read data; it holds between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= (reg_sel == SEL_STATUS) ? status_byte : en_q;
    end

    AST_IRQ_MATCHES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_src != 3'd0));                                  // R11
    AST_SLEEP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> sleep_en == $past(reg_wdata[EN_SLEEP]));         // R3
    AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~(DATA_W'(1) << EN_SLEEP)) == '0 |-> !irq);         // R10

endmodule

// File: tb/tb_uirq_ctrl.sv
// Scoreboard bench for uirq_ctrl. The driver changes inputs at the
// falling edge and queues what the outputs must be after the next
// rising edge. The monitor compares them 3 ns after that edge.
module tb_uirq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_ready = 1'b0, tx_empty = 1'b0, line_err = 1'b0;
    logic [3:0] modem_delta = '0;
    logic       xoff_seen = 1'b0, cts_line = 1'b0, rts_line = 1'b0;
    logic       irq, sleep_en;
    logic [2:0] irq_src;

    always #4 clk = ~clk;

    uirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_ready(rx_ready), .tx_empty(tx_empty), .line_err(line_err),
        .modem_delta(modem_delta), .xoff_seen(xoff_seen),
        .cts_line(cts_line), .rts_line(rts_line),
        .irq(irq), .irq_src(irq_src), .sleep_en(sleep_en)
    );

    typedef struct {
        string      tag;
        int         kind;   // 0: {irq, irq_src}, 1: reg_rdata, 2: sleep_en
        logic [7:0] val;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic exp_irq(string tag, logic i, logic [2:0] c);
        exp_t e; e.tag = tag; e.kind = 0; e.val = {4'b0, i, c}; q.push_back(e);
    endtask
    task automatic exp_rd(string tag, logic [7:0] v);
        exp_t e; e.tag = tag; e.kind = 1; e.val = v; q.push_back(e);
    endtask
    task automatic exp_sleep(string tag, logic v);
        exp_t e; e.tag = tag; e.kind = 2; e.val = {7'b0, v}; q.push_back(e);
    endtask

    // Drive the register port at the falling edge
    task automatic port(logic wr, logic rd, logic sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = d;
    endtask
    task automatic idle();
        port(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    // Monitor: pop and compare every queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = q.pop_front();
                case (e.kind)
                    0:       act = {4'b0, irq, irq_src};
                    1:       act = reg_rdata;
                    default: act = {7'b0, sleep_en};
                endcase
                n_checks++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s kind %0d actual %h expected %h", e.tag, e.kind, act, e.val);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset, then release with every level source active
        repeat (2) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rx_ready = 1'b1; tx_empty = 1'b1; line_err = 1'b1; modem_delta = 4'hF;
        exp_irq("R1", 1'b0, 3'd0); exp_rd("R1", 8'h00); exp_sleep("R1", 1'b0);

        // R4 and R9: level sources and their order
        port(1'b1, 1'b0, 1'b0, 8'h01); exp_irq("R4 rx", 1'b1, 3'd2);
        port(1'b1, 1'b0, 1'b0, 8'h03); exp_irq("R9 rx over tx", 1'b1, 3'd2);
        port(1'b1, 1'b0, 1'b0, 8'h02); exp_irq("R4 tx", 1'b1, 3'd3);
        port(1'b1, 1'b0, 1'b0, 8'h07); exp_irq("R9 line first", 1'b1, 3'd1);
        port(1'b1, 1'b0, 1'b0, 8'h08); exp_irq("R5 modem", 1'b1, 3'd4);
        // R3: sleep bit is exported and raises nothing
        port(1'b1, 1'b0, 1'b0, 8'h10); exp_irq("R3", 1'b0, 3'd0); exp_sleep("R3", 1'b1);
        // R2: readback
        port(1'b0, 1'b1, 1'b0, 8'h00); exp_rd("R2", 8'h10);

        // R5: one modem bit alone, then none
        port(1'b1, 1'b0, 1'b0, 8'h08);
        rx_ready = 1'b0; tx_empty = 1'b0; line_err = 1'b0; modem_delta = 4'b0100;
        exp_irq("R5 one bit", 1'b1, 3'd4);
        idle(); modem_delta = 4'b0000; exp_irq("R5 none", 1'b0, 3'd0);

        // R7: Xoff pulse while disabled, enabled later
        port(1'b1, 1'b0, 1'b0, 8'h00); xoff_seen = 1'b1; exp_irq("R7 masked", 1'b0, 3'd0);
        port(1'b1, 1'b0, 1'b0, 8'h20); xoff_seen = 1'b0; exp_irq("R7 sticky", 1'b1, 3'd5);
        // R10: disable then re-enable keeps the flag
        port(1'b1, 1'b0, 1'b0, 8'h00); exp_irq("R10 off", 1'b0, 3'd0);
        port(1'b1, 1'b0, 1'b0, 8'h20); exp_irq("R10 back", 1'b1, 3'd5);
        // R8: status read returns old flags and clears them
        port(1'b0, 1'b1, 1'b1, 8'h00); exp_rd("R8 xoff", 8'h25); exp_irq("R8 cleared", 1'b0, 3'd0);
        port(1'b0, 1'b1, 1'b1, 8'h00); exp_rd("R8 empty", 8'h00);

        // R6: CTS rising edge
        port(1'b1, 1'b0, 1'b0, 8'hC0); exp_irq("R6 none yet", 1'b0, 3'd0);
        idle(); cts_line = 1'b1; exp_irq("R6 cts", 1'b1, 3'd6);
        idle(); exp_irq("R6 held", 1'b1, 3'd6);
        port(1'b0, 1'b1, 1'b1, 8'h00); exp_rd("R6 status", 8'h86); exp_irq("R6 clr", 1'b0, 3'd0);
        idle(); exp_irq("R6 high level no edge", 1'b0, 3'd0);

        // R8: clear and new RTS edge on the same edge
        idle(); cts_line = 1'b0; exp_irq("R6 fall", 1'b0, 3'd0);
        idle(); cts_line = 1'b1; exp_irq("R6 cts again", 1'b1, 3'd6);
        port(1'b0, 1'b1, 1'b1, 8'h00); rts_line = 1'b1;
        exp_rd("R8 same edge", 8'h86); exp_irq("R8 set wins", 1'b1, 3'd6);
        port(1'b0, 1'b1, 1'b1, 8'h00); exp_rd("R8 rts left", 8'h46); exp_irq("R8 all clr", 1'b0, 3'd0);

        // R9: Xoff above CTS/RTS
        port(1'b1, 1'b0, 1'b0, 8'hE0); cts_line = 1'b0; exp_irq("R9 idle", 1'b0, 3'd0);
        idle(); xoff_seen = 1'b1; cts_line = 1'b1; exp_irq("R9 xoff first", 1'b1, 3'd5);
        port(1'b1, 1'b0, 1'b0, 8'hC0); xoff_seen = 1'b0; exp_irq("R9 cts after", 1'b1, 3'd6);
        port(1'b0, 1'b1, 1'b1, 8'h00); exp_rd("R8 both", 8'hA6);

        // R12: writes to the status selector change nothing
        port(1'b1, 1'b0, 1'b1, 8'hFF); exp_irq("R12 irq", 1'b0, 3'd0); exp_sleep("R12 sleep", 1'b0);
        port(1'b0, 1'b1, 1'b0, 8'h00); exp_rd("R12 readback", 8'hC0);

        // R6: falling lines set nothing
        idle(); cts_line = 1'b0; rts_line = 1'b0; exp_irq("R6 falling", 1'b0, 3'd0);
        idle(); exp_irq("R11 quiet", 1'b0, 3'd0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule